// File: doc/BRIEF.md
# Virtual Address Translation and Access Check

This block turns a 32-bit virtual address into a physical address for one instruction fetch or data access per request. The address is first decoded against fixed regions. One window bypasses translation by dropping the top three bits. A high control window passes through unchanged. User-mode access to the privileged windows is refused. The remaining addresses are mapped directly when translation is off. Otherwise they are looked up in a fully associative table of page entries, which the surrounding logic supplies as a flat vector.

A table lookup compares each valid entry against the address at that entry's own page size. An address-space identifier is compared unless the entry is marked shared or the core runs privileged in single-address-space mode. The lookup then checks the access rights and the dirty bit of the single hit. A bad access produces a distinct fault code for each class of problem. A good access produces the physical address, made from the page number of the entry and the offset bits of the virtual address.

The lookup is combinational and the result is registered once, so each request is answered one clock later with a response strobe, a fault strobe and either a physical address or a fault code.

Top module: `va_xlate`

## Requirements
- R1: A request on `reqValid` is answered on the next clock with `rspValid` high. `faultValid` is only ever high together with `rspValid`. With no request, both strobes are low. After reset, `rspValid`, `faultValid`, `paddr` and `faultCode` are zero. On a fault, `paddr` reads zero. On success, `faultCode` reads zero.
- R2: In privileged mode, addresses 0x80000000 to 0xBFFFFFFF are never translated. The physical address is the virtual address with bits 31:29 cleared.
- R3: In user mode, addresses 0x80000000 to 0xBFFFFFFF and 0xE4000000 to 0xFFFFFFFF give an address error. The code is 0x100 for a data write and 0x0E0 for a data read or a fetch; a fetch always counts as a read. Addresses 0xE0000000 to 0xE3FFFFFF are allowed in both modes. Addresses 0xE0000000 and up, when allowed, pass through unchanged.
- R4: When `mmuOn` is low, addresses below 0x80000000 and 0xC0000000 to 0xDFFFFFFF map to the address with bits 31:29 cleared, with no rights check.
- R5: The identifier is compared only when `singleVirt` is low or `privMode` is low. An entry with its shared bit set matches whatever its identifier.
- R6: Entry i occupies `tlbFlat[i*56 +: 56]`, laid out as: bit 55 valid, 54 shared, 53:46 identifier, 45:24 virtual page number, 23:5 physical page number, 4:3 size code, 2:1 rights, 0 dirty. Size codes 0, 1, 2 and 3 select 1 KB, 4 KB, 64 KB and 1 MB pages. The page base is the virtual page number shifted left by 10, with bits below the page size ignored.
- R7: More than one valid matching entry gives fault code 0x140. An invalid entry never matches.
- R8: No matching entry gives 0x040 for a read or a fetch and 0x060 for a data write.
- R9: A user-mode access to an entry whose rights bit 1 (flat bit 2) is clear gives 0x0A0 for a read or a fetch and 0x0C0 for a data write.
- R10: A data write to an entry whose rights bit 0 (flat bit 1) is clear gives 0x0C0. A data write to a writable entry whose dirty bit is clear gives 0x080. Fetches and reads ignore both bits.
- R11: On a hit, the physical address takes its bits above the page size from the physical page number shifted left by 10, and its bits below the page size from the virtual address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe |
| vaddr | input | 32 | Virtual address |
| isWrite | input | 1 | Data access is a write |
| isFetch | input | 1 | Access is an instruction fetch |
| privMode | input | 1 | Core in privileged mode |
| mmuOn | input | 1 | Translation enabled |
| singleVirt | input | 1 | Single-address-space mode |
| curAsid | input | 8 | Current address-space identifier |
| tlbFlat | input | NUM_ENT*56 | Flattened entry table |
| rspValid | output | 1 | Response strobe, one clock after the request |
| paddr | output | 32 | Physical address (zero on fault) |
| faultValid | output | 1 | Fault strobe |
| faultCode | output | 12 | Fault code (zero on success) |

## Verification
The bench builds the block with four entries. Four entries are enough to place overlapping pages for the multiple-hit case and spare invalid or foreign-identifier entries beside them. They also keep the number of input combinations small. This makes full sweeps practical: the fixed-region probe addresses are crossed with every combination of privilege, write, fetch and enable, and every rights and dirty combination is tried in both modes. Each page size is probed at its first and last byte and one byte outside on each side, with deliberately misaligned page numbers, so the alignment and offset split are tested at the boundaries.

// File: rtl/va_xlate_pkg.sv
package va_xlate_pkg;
  localparam int VA_W     = 32;
  localparam int ASID_W   = 8;
  localparam int VPN_W    = 22;
  localparam int PPN_W    = 19;
  localparam int PG_SHIFT = 10;
  localparam int CODE_W   = 12;
  localparam int PA_PAD   = VA_W - PPN_W - PG_SHIFT;
  localparam int ENT_W    = 2 + ASID_W + VPN_W + PPN_W + 2 + 2 + 1;

  localparam logic [CODE_W-1:0] FC_NONE      = 12'h000;
  localparam logic [CODE_W-1:0] FC_RD_MISS   = 12'h040;
  localparam logic [CODE_W-1:0] FC_WR_MISS   = 12'h060;
  localparam logic [CODE_W-1:0] FC_FIRST_WR  = 12'h080;
  localparam logic [CODE_W-1:0] FC_RD_PROT   = 12'h0A0;
  localparam logic [CODE_W-1:0] FC_WR_PROT   = 12'h0C0;
  localparam logic [CODE_W-1:0] FC_RD_ADDR   = 12'h0E0;
  localparam logic [CODE_W-1:0] FC_WR_ADDR   = 12'h100;
  localparam logic [CODE_W-1:0] FC_MULTI     = 12'h140;

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [1:0]        sizeCode;
    logic [1:0]        prot;
    logic              dirty;
  } tlbEntry_t;

  typedef enum logic [1:0] {PA_KEEP, PA_LOW29, PA_PAGE} paSel_e;

  // datapath -> control
  typedef struct packed {
    logic       regionBypass;
    logic       regionHigh;
    logic       regionStoreWin;
    logic       noHit;
    logic       multiHit;
    logic [1:0] hitProt;
    logic       hitDirty;
  } dpFlags_t;

  // control -> datapath
  typedef struct packed {
    logic   load;
    logic   zeroPa;
    paSel_e paSel;
  } ctlStrobe_t;

  function automatic logic [VA_W-1:0] pageMask(input logic [1:0] sizeCode);
    int bits;
    case (sizeCode)
      2'd0:    bits = 10;
      2'd1:    bits = 12;
      2'd2:    bits = 16;
      default: bits = 20;
    endcase
    return (VA_W'(1) << bits) - VA_W'(1);
  endfunction
endpackage

// File: rtl/va_xlate_dp.sv
module va_xlate_dp
  import va_xlate_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [VA_W-1:0]          vaddr,
  input  logic                     privMode,
  input  logic                     singleVirt,
  input  logic [ASID_W-1:0]        curAsid,
  input  logic [NUM_ENT*ENT_W-1:0] tlbFlat,
  input  ctlStrobe_t               strobe,
  output dpFlags_t                 flags,
  output logic [VA_W-1:0]          paddr
);
  localparam int TOP_BITS = VA_W - 29;

  logic                useAsid;
  logic [NUM_ENT-1:0]  matchVec;
  logic [VA_W-1:0]     pageArr  [NUM_ENT];
  logic [1:0]          protArr  [NUM_ENT];
  logic                dirtyArr [NUM_ENT];
  logic [VA_W-1:0]     hitPa;
  logic [1:0]          hitProt;
  logic                hitDirty;
  logic [VA_W-1:0]     paNext;

  assign useAsid = !singleVirt || !privMode;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    tlbEntry_t       ent;
    logic [VA_W-1:0] lowMask;
    logic [VA_W-1:0] vBase;
    logic [VA_W-1:0] pBase;
    logic            asidOk;
    assign ent     = tlbEntry_t'(tlbFlat[i*ENT_W +: ENT_W]);
    assign lowMask = pageMask(ent.sizeCode);
    assign vBase   = {ent.vpn, {PG_SHIFT{1'b0}}};
    assign pBase   = {{PA_PAD{1'b0}}, ent.ppn, {PG_SHIFT{1'b0}}};
    assign asidOk  = ent.shared || !useAsid || (ent.asid == curAsid);
    assign matchVec[i] = ent.valid && asidOk &&
                         ((vaddr & ~lowMask) == (vBase & ~lowMask));
    assign pageArr[i]  = (pBase & ~lowMask) | (vaddr & lowMask);
    assign protArr[i]  = ent.prot;
    assign dirtyArr[i] = ent.dirty;
  end

  // one-hot OR mux; result only used when exactly one entry hits
  always_comb begin
    hitPa    = '0;
    hitProt  = '0;
    hitDirty = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (matchVec[i]) begin
        hitPa    = hitPa | pageArr[i];
        hitProt  = hitProt | protArr[i];
        hitDirty = hitDirty | dirtyArr[i];
      end
    end
  end

  always_comb begin
    flags.regionBypass   = (vaddr[VA_W-1 -: 2] == 2'b10);
    flags.regionHigh     = (vaddr[VA_W-1 -: 3] == 3'b111);
    flags.regionStoreWin = (vaddr[VA_W-1 -: 6] == 6'b111000);
    flags.noHit          = (matchVec == '0);
    flags.multiHit       = |(matchVec & (matchVec - NUM_ENT'(1)));
    flags.hitProt        = hitProt;
    flags.hitDirty       = hitDirty;
  end

  always_comb begin
    case (strobe.paSel)
      PA_LOW29: paNext = {{TOP_BITS{1'b0}}, vaddr[28:0]};
      PA_PAGE:  paNext = hitPa;
      default:  paNext = vaddr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr <= '0;
    end else if (strobe.load) begin
      paddr <= strobe.zeroPa ? '0 : paNext;
    end
  end
endmodule

// File: rtl/va_xlate_ctl.sv
module va_xlate_ctl
  import va_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              isWrite,
  input  logic              isFetch,
  input  logic              privMode,
  input  logic              mmuOn,
  input  dpFlags_t          flags,
  output ctlStrobe_t        strobe,
  output logic              rspValid,
  output logic              faultValid,
  output logic [CODE_W-1:0] faultCode
);
  logic              wrData;
  logic              faultNow;
  logic [CODE_W-1:0] codeNow;
  paSel_e            selNow;

  assign wrData = isWrite && !isFetch;

  always_comb begin
    faultNow = 1'b0;
    codeNow  = FC_NONE;
    selNow   = PA_KEEP;
    if (flags.regionBypass || flags.regionHigh) begin
      if (!privMode && !flags.regionStoreWin) begin
        faultNow = 1'b1;
        codeNow  = wrData ? FC_WR_ADDR : FC_RD_ADDR;
      end else begin
        selNow = flags.regionBypass ? PA_LOW29 : PA_KEEP;
      end
    end else if (!mmuOn) begin
      selNow = PA_LOW29;
    end else if (flags.multiHit) begin
      faultNow = 1'b1;
      codeNow  = FC_MULTI;
    end else if (flags.noHit) begin
      faultNow = 1'b1;
      codeNow  = wrData ? FC_WR_MISS : FC_RD_MISS;
    end else if (!privMode && !flags.hitProt[1]) begin
      faultNow = 1'b1;
      codeNow  = wrData ? FC_WR_PROT : FC_RD_PROT;
    end else if (wrData && !flags.hitProt[0]) begin
      faultNow = 1'b1;
      codeNow  = FC_WR_PROT;
    end else if (wrData && !flags.hitDirty) begin
      faultNow = 1'b1;
      codeNow  = FC_FIRST_WR;
    end else begin
      selNow = PA_PAGE;
    end
  end

  always_comb begin
    strobe.load   = reqValid;
    strobe.zeroPa = faultNow;
    strobe.paSel  = selNow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid   <= 1'b0;
      faultValid <= 1'b0;
      faultCode  <= FC_NONE;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        faultValid <= faultNow;
        faultCode  <= codeNow;
      end else begin
        faultValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/va_xlate.sv
module va_xlate
  import va_xlate_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reqValid,
  input  logic [31:0]              vaddr,
  input  logic                     isWrite,
  input  logic                     isFetch,
  input  logic                     privMode,
  input  logic                     mmuOn,
  input  logic                     singleVirt,
  input  logic [7:0]               curAsid,
  input  logic [NUM_ENT*56-1:0]    tlbFlat,
  output logic                     rspValid,
  output logic [31:0]              paddr,
  output logic                     faultValid,
  output logic [11:0]              faultCode
);
  dpFlags_t   flags;
  ctlStrobe_t strobe;

  va_xlate_dp #(.NUM_ENT(NUM_ENT)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .vaddr      (vaddr),
    .privMode   (privMode),
    .singleVirt (singleVirt),
    .curAsid    (curAsid),
    .tlbFlat    (tlbFlat),
    .strobe     (strobe),
    .flags      (flags),
    .paddr      (paddr)
  );

  va_xlate_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .isWrite    (isWrite),
    .isFetch    (isFetch),
    .privMode   (privMode),
    .mmuOn      (mmuOn),
    .flags      (flags),
    .strobe     (strobe),
    .rspValid   (rspValid),
    .faultValid (faultValid),
    .faultCode  (faultCode)
  );
endmodule

// File: rtl/va_xlate_chk.sv
module va_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reqValid,
  input logic [31:0] vaddr,
  input logic        isWrite,
  input logic        isFetch,
  input logic        privMode,
  input logic        mmuOn,
  input logic        rspValid,
  input logic [31:0] paddr,
  input logic        faultValid,
  input logic [11:0] faultCode
);
  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> (!rspValid && !faultValid));

  p_fault_qualified_r1: assert property (@(posedge clk) disable iff (!rst_n)
    faultValid |-> rspValid);

  p_bypass_low29_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && privMode && vaddr[31:30] == 2'b10) |=>
      (!faultValid && paddr == {3'b000, $past(vaddr[28:0])}));

  p_user_addr_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !privMode &&
     (vaddr[31:30] == 2'b10 || (vaddr[31:29] == 3'b111 && vaddr[28:26] != 3'b000))) |=>
      (faultValid && faultCode == ($past(isWrite && !isFetch) ? 12'h100 : 12'h0E0)));

  p_direct_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !mmuOn && !vaddr[31]) |=>
      (!faultValid && paddr == {3'b000, $past(vaddr[28:0])}));

  p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    faultValid |-> (faultCode inside {12'h040, 12'h060, 12'h080, 12'h0A0,
                                      12'h0C0, 12'h0E0, 12'h100, 12'h140}));
endmodule

bind va_xlate va_xlate_chk u_chk (.*);

// File: tb/va_xlate_tb.sv
module va_xlate_tb;
  localparam int NE = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reqValid = 1'b0;
  logic [31:0]   vaddr = '0;
  logic          isWrite = 1'b0;
  logic          isFetch = 1'b0;
  logic          privMode = 1'b0;
  logic          mmuOn = 1'b0;
  logic          singleVirt = 1'b0;
  logic [7:0]    curAsid = '0;
  logic [NE*56-1:0] tlbFlat;
  logic          rspValid;
  logic [31:0]   paddr;
  logic          faultValid;
  logic [11:0]   faultCode;

  // bench-side table
  logic        eV   [NE];
  logic        eSh  [NE];
  logic [7:0]  eAs  [NE];
  logic [21:0] eVpn [NE];
  logic [18:0] ePpn [NE];
  logic [1:0]  eSz  [NE];
  logic [1:0]  ePr  [NE];
  logic        eD   [NE];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NE; i++)
      tlbFlat[i*56 +: 56] = {eV[i], eSh[i], eAs[i], eVpn[i], ePpn[i], eSz[i], ePr[i], eD[i]};
  end

  va_xlate #(.NUM_ENT(NE)) u_dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int pgBits(input logic [1:0] s);
    return (s == 0) ? 10 : (s == 1) ? 12 : (s == 2) ? 16 : 20;
  endfunction

  // independent reference from the requirements
  function automatic void refModel(input logic [31:0] va, input bit wr, fe, pv, mo, sv,
                                   input logic [7:0] ca,
                                   output bit f, output logic [11:0] c, output logic [31:0] pa);
    bit dw = wr && !fe;
    int hits = 0;
    int hi = 0;
    f = 0; c = 0; pa = 0;
    if ((va >= 32'h8000_0000 && va < 32'hC000_0000) || va >= 32'hE000_0000) begin
      if (!pv && !(va >= 32'hE000_0000 && va < 32'hE400_0000)) begin
        f = 1; c = dw ? 12'h100 : 12'h0E0; return;
      end
      pa = (va < 32'hC000_0000) ? va % 32'h2000_0000 : va;
      return;
    end
    if (!mo) begin pa = va % 32'h2000_0000; return; end
    for (int i = 0; i < NE; i++) begin
      longint sz = longint'(1) << pgBits(eSz[i]);
      longint st = (longint'(eVpn[i]) * 1024) / sz * sz;
      bit aOk = eSh[i] || (sv && pv) || eAs[i] == ca;
      if (eV[i] && aOk && longint'(va) >= st && longint'(va) <= st + sz - 1) begin
        hits++; hi = i;
      end
    end
    if (hits > 1) begin f = 1; c = 12'h140; return; end
    if (hits == 0) begin f = 1; c = dw ? 12'h060 : 12'h040; return; end
    if (!pv && !ePr[hi][1]) begin f = 1; c = dw ? 12'h0C0 : 12'h0A0; return; end
    if (dw && !ePr[hi][0]) begin f = 1; c = 12'h0C0; return; end
    if (dw && !eD[hi]) begin f = 1; c = 12'h080; return; end
    begin
      longint sz = longint'(1) << pgBits(eSz[hi]);
      longint pb = (longint'(ePpn[hi]) * 1024) / sz * sz;
      pa = 32'(pb + (longint'(va) % sz));
    end
  endfunction

  task automatic runOne(input logic [31:0] va, input bit wr, fe, pv, mo, sv,
                        input logic [7:0] ca, input string tag);
    bit ef; logic [11:0] ec; logic [31:0] ep;
    @(negedge clk);
    vaddr = va; isWrite = wr; isFetch = fe; privMode = pv; mmuOn = mo;
    singleVirt = sv; curAsid = ca; reqValid = 1'b1;
    refModel(va, wr, fe, pv, mo, sv, ca, ef, ec, ep);
    @(negedge clk);
    reqValid = 1'b0;
    checks++;
    if (rspValid !== 1'b1 || faultValid !== ef || faultCode !== ec || paddr !== ep) begin
      errors++;
      $display("FAIL %s va=%h wr=%0d fe=%0d pv=%0d mo=%0d: actual rsp=%0b f=%0b c=%h pa=%h expected rsp=1 f=%0b c=%h pa=%h",
               tag, va, wr, fe, pv, mo, rspValid, faultValid, faultCode, paddr, ef, ec, ep);
    end
  endtask

  task automatic clearTable();
    for (int i = 0; i < NE; i++) begin
      eV[i] = 0; eSh[i] = 0; eAs[i] = 0; eVpn[i] = 0;
      ePpn[i] = 0; eSz[i] = 0; ePr[i] = 0; eD[i] = 0;
    end
  endtask

  task automatic setEnt(input int i, input logic [31:0] va, input logic [18:0] ppn,
                        input logic [1:0] sz, input logic [7:0] as, input bit sh,
                        input logic [1:0] pr, input bit d);
    eV[i] = 1; eSh[i] = sh; eAs[i] = as; eVpn[i] = va[31:10];
    ePpn[i] = ppn; eSz[i] = sz; ePr[i] = pr; eD[i] = d;
  endtask

  logic [31:0] regionProbe [11] = '{32'h0000_1234, 32'h7FFF_FFFF, 32'h8000_0000,
    32'h9ABC_DEF0, 32'hBFFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFC, 32'hE000_0000,
    32'hE3FF_FFFF, 32'hE400_0000, 32'hFFFF_FFFF};

  initial begin
    clearTable();
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (rspValid !== 0 || faultValid !== 0 || paddr !== 0 || faultCode !== 0) begin
      errors++;
      $display("FAIL R1 reset: actual rsp=%0b f=%0b pa=%h c=%h expected all zero",
               rspValid, faultValid, paddr, faultCode);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R8: fixed regions crossed with every mode, empty table
    foreach (regionProbe[k])
      for (int m = 0; m < 32; m++)
        runOne(regionProbe[k], m[0], m[1], m[2], m[3], m[4], 8'h00, "R2_R3_R4_R8 region");

    // R1: idle cycle gives no response
    @(negedge clk);
    checks++;
    if (rspValid !== 0 || faultValid !== 0) begin
      errors++;
      $display("FAIL R1 idle: actual rsp=%0b f=%0b expected 0 0", rspValid, faultValid);
    end

    // R6 R11: each page size, misaligned page numbers, boundary probes
    for (int s = 0; s < 4; s++) begin
      logic [31:0] base = 32'h1230_0000;
      logic [31:0] sz = 32'd1 << pgBits(2'(s));
      clearTable();
      setEnt(0, (s == 0) ? base : (base | 32'h0000_0C00), 19'h5A5A5, 2'(s), 8'h07, 0, 2'b11, 1);
      for (int m = 0; m < 8; m++) begin
        runOne(base,                   m[0], m[1], m[2], 1, 0, 8'h07, "R6_R11 first");
        runOne(base + sz - 1,          m[0], m[1], m[2], 1, 0, 8'h07, "R6_R11 last");
        runOne(base + sz,              m[0], m[1], m[2], 1, 0, 8'h07, "R6 above");
        runOne(base - 1,               m[0], m[1], m[2], 1, 0, 8'h07, "R6 below");
        runOne(base + (sz >> 1) + 32'h37, m[0], m[1], m[2], 1, 0, 8'h07, "R11 middle");
      end
    end

    // R5: identifier compare and shared bypass
    for (int m = 0; m < 32; m++) begin
      clearTable();
      setEnt(1, 32'h4000_0000, 19'h01234, 2'd3, 8'h12, m[0], 2'b11, 1);
      runOne(32'h4001_2340, m[3], 0, m[2], 1, m[1], m[4] ? 8'h34 : 8'h12, "R5 asid");
    end

    // R7: overlapping entries
    clearTable();
    setEnt(0, 32'h2000_0000, 19'h10000, 2'd3, 8'h05, 0, 2'b11, 1);
    setEnt(2, 32'h2004_5000, 19'h20000, 2'd1, 8'h05, 0, 2'b11, 1);
    for (int m = 0; m < 4; m++) begin
      runOne(32'h2004_5678, m[0], 0, m[1], 1, 0, 8'h05, "R7 multi");
      runOne(32'h2008_0000, m[0], 0, m[1], 1, 0, 8'h05, "R7 single");
    end
    eV[2] = 0;
    runOne(32'h2004_5678, 0, 0, 1, 1, 0, 8'h05, "R7 invalid overlap");
    eV[2] = 1; eAs[2] = 8'h06;
    runOne(32'h2004_5678, 0, 0, 0, 1, 0, 8'h05, "R7 foreign asid");
    runOne(32'h2004_5678, 0, 0, 1, 1, 1, 8'h05, "R7 single-space multi");

    // R9 R10: rights and dirty combinations
    for (int m = 0; m < 64; m++) begin
      clearTable();
      setEnt(3, 32'h0001_0000, 19'h3FFC0, 2'd2, 8'h09, 0, m[1:0], m[2]);
      runOne(32'h0001_ABCD, m[3], m[4], m[5], 1, 0, 8'h09, "R9_R10 rights");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule